// File: doc/BRIEF.md
# Window Line Address Generator

This block produces the memory read requests that fetch one overlay window of a frame, one scan line after another. Software gives it a line start address and an end address, a packed stride word that holds the useful bytes per line and the gap to skip between lines, a field-layout select, the pixel format and the framebuffer width in pixels. A single-cycle `start_i` latches all of these. The block then walks the window. Each line is cut into equal bursts plus one shorter tail burst. After the last burst of a line it jumps over the gap to the next line start.

The end address is expected to be the first line start plus the pitch times the source height, where the pitch is the line width plus the gap. Generation stops at the first line start that reaches or passes it. The block then raises a completion flag and holds it until the next start. Requests leave on a ready/valid channel that carries a byte address and a byte length.

Top module: `win_line_addr_gen`

## Requirements
- R1: After reset no request is valid, and both `busy_o` and `done_o` are low.
- R2: A `start_i` pulse while idle latches every configuration input. The first request address equals `base_addr_i`. A `start_i` pulse while busy is ignored, and the sequence in flight carries on unchanged.
- R3: With `alt_layout_i`=0 the line width is `stride_word_i[13:0]` and the gap is `stride_word_i[27:14]`. Bits 31:28 are ignored.
- R4: With `alt_layout_i`=1 the line width is `stride_word_i[14:0]` and the gap is `stride_word_i[29:15]`. Bits 31:30 are ignored.
- R5: The full burst is 64 bytes (16 words of 4 bytes) for every pixel format code: 0 = 16-bit 1555, 1 = 16-bit 565, 2 = 24-bit in a 32-bit word, 3 = 32-bit with alpha. This holds when `fb_width_i` is 128 or more.
- R6: When `fb_width_i` is below 128, the full burst is 32 bytes (8 words) for every format.
- R7: Within a line, bursts are issued at consecutive addresses. Each one is a full burst except the last, which carries the remaining bytes (1 up to the full burst).
- R8: After the last burst of a line, the next line starts at the previous line start plus the line width plus the gap.
- R9: When the next line start is at or past the end address, no further request is made. `done_o` rises in the cycle after the final accepted request and stays high until the next accepted start.
- R10: A valid request that is not accepted keeps its address and length unchanged in the next cycle.
- R11: If the line width is zero, or the start address is at or past the end address, `done_o` rises one cycle after the start and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; honoured only while idle |
| base_addr_i | input | 32 | First line start address |
| end_addr_i | input | 32 | End address of the window |
| stride_word_i | input | 32 | Packed gap and line-width fields |
| alt_layout_i | input | 1 | Selects the wide field layout |
| pix_fmt_i | input | 2 | Pixel format code |
| fb_width_i | input | 13 | Framebuffer width in pixels |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted when high with valid |
| req_addr_o | output | 32 | Request byte address |
| req_len_o | output | 7 | Request length in bytes |
| busy_o | output | 1 | A window walk is in progress |
| done_o | output | 1 | Walk finished; held until next start |

## Verification
Random windows vary the line width, gap, height, field layout, format and framebuffer width, with a randomly stalling ready. Line widths that divide evenly into bursts are separated from those that leave a tail. Gaps of zero are separated from non-zero gaps. Framebuffer widths on either side of 128 distinguish the two burst sizes. Directed cases cover a width of exactly 127 and 128, a zero line width, an end address equal to the start, a line width that needs bit 14 in the wide layout, junk in the unused top bits, and a start pulse issued while a walk is in progress.

// File: rtl/win_line_addr_gen_pkg.sv
package win_line_addr_gen_pkg;
  typedef enum logic [1:0] {
    FMT_XRGB1555 = 2'd0,
    FMT_RGB565   = 2'd1,
    FMT_XRGB888  = 2'd2,
    FMT_ARGB8888 = 2'd3
  } pix_fmt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_state_e;

  // full-burst word count per format when the buffer is wide
  function automatic int unsigned long_burst_words(pix_fmt_e fmt);
    case (fmt)
      FMT_XRGB1555, FMT_RGB565:  return 16;
      FMT_XRGB888, FMT_ARGB8888: return 16;
      default:                   return 16;
    endcase
  endfunction
endpackage

// File: rtl/wlag_stride_unpack.sv
module wlag_stride_unpack #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NRM_FLD_W = 14,
  parameter int unsigned ALT_FLD_W = 15,
  localparam int unsigned FLD_W   = (ALT_FLD_W > NRM_FLD_W) ? ALT_FLD_W : NRM_FLD_W
) (
  input  logic [WORD_W-1:0] stride_word_i,
  input  logic              alt_layout_i,
  output logic [FLD_W-1:0]  page_w_o,
  output logic [FLD_W-1:0]  gap_o
);
  logic [FLD_W-1:0] nrm_pw, nrm_gap, alt_pw, alt_gap;

  always_comb begin
    nrm_pw  = '0;
    nrm_gap = '0;
    alt_pw  = '0;
    alt_gap = '0;
    nrm_pw[NRM_FLD_W-1:0]  = stride_word_i[NRM_FLD_W-1:0];
    nrm_gap[NRM_FLD_W-1:0] = stride_word_i[2*NRM_FLD_W-1:NRM_FLD_W];
    alt_pw[ALT_FLD_W-1:0]  = stride_word_i[ALT_FLD_W-1:0];
    alt_gap[ALT_FLD_W-1:0] = stride_word_i[2*ALT_FLD_W-1:ALT_FLD_W];
  end

  assign page_w_o = alt_layout_i ? alt_pw  : nrm_pw;
  assign gap_o    = alt_layout_i ? alt_gap : nrm_gap;
endmodule

// File: rtl/wlag_burst_sel.sv
module wlag_burst_sel
  import win_line_addr_gen_pkg::*;
#(
  parameter int unsigned FBW_W        = 13,
  parameter int unsigned NARROW_LIMIT = 128,
  parameter int unsigned SHORT_WORDS  = 8,
  parameter int unsigned WORD_BYTES   = 4,
  parameter int unsigned LEN_W        = 7
) (
  input  pix_fmt_e          fmt_i,
  input  logic [FBW_W-1:0]  fb_width_i,
  output logic [LEN_W-1:0]  burst_bytes_o
);
  localparam logic [FBW_W-1:0] LIMIT = FBW_W'(NARROW_LIMIT);
  localparam logic [LEN_W-1:0] SHORT_BYTES = LEN_W'(SHORT_WORDS * WORD_BYTES);

  logic [LEN_W-1:0] long_bytes;
  always_comb long_bytes = LEN_W'(long_burst_words(fmt_i) * WORD_BYTES);

  // narrow buffers tear with long bursts
  assign burst_bytes_o = (fb_width_i < LIMIT) ? SHORT_BYTES : long_bytes;
endmodule

// File: rtl/wlag_walker.sv
module wlag_walker
  import win_line_addr_gen_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PW_W   = 15,
  parameter int unsigned LEN_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic [PW_W-1:0]   page_w_i,
  input  logic [PW_W-1:0]   gap_i,
  input  logic [LEN_W-1:0]  burst_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              busy_o,
  output logic              done_o
);
  walk_state_e       state_q;
  logic [ADDR_W-1:0] line_q, end_q;
  logic [PW_W-1:0]   pos_q, pw_q, gap_q;
  logic [LEN_W-1:0]  burst_q;
  logic              done_q;

  logic [PW_W-1:0]   rem;
  logic [PW_W-1:0]   burst_ext;
  logic              tail;
  logic [ADDR_W:0]   next_line;
  logic              past_end;
  logic              empty_win;
  logic              fire;

  assign rem       = pw_q - pos_q;
  assign burst_ext = PW_W'(burst_q);
  assign tail      = (rem <= burst_ext);
  assign next_line = {1'b0, line_q} + (ADDR_W+1)'(pw_q) + (ADDR_W+1)'(gap_q);
  assign past_end  = (next_line >= {1'b0, end_q});
  assign empty_win = (page_w_i == '0) || (base_i >= end_i);
  assign fire      = (state_q == ST_RUN) && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      end_q   <= '0;
      pos_q   <= '0;
      pw_q    <= '0;
      gap_q   <= '0;
      burst_q <= '0;
      done_q  <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        line_q  <= base_i;
        end_q   <= end_i;
        pos_q   <= '0;
        pw_q    <= page_w_i;
        gap_q   <= gap_i;
        burst_q <= burst_i;
        done_q  <= empty_win;
        state_q <= empty_win ? ST_IDLE : ST_RUN;
      end
    end else if (fire) begin
      if (tail) begin
        pos_q <= '0;
        if (past_end) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          line_q <= next_line[ADDR_W-1:0];
        end
      end else begin
        pos_q <= pos_q + burst_ext;
      end
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = done_q;
  assign addr_o  = line_q + ADDR_W'(pos_q);
  assign len_o   = tail ? rem[LEN_W-1:0] : burst_q;
endmodule

// File: rtl/win_line_addr_gen.sv
module win_line_addr_gen
  import win_line_addr_gen_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned FBW_W        = 13,
  parameter int unsigned NRM_FLD_W    = 14,
  parameter int unsigned ALT_FLD_W    = 15,
  parameter int unsigned NARROW_LIMIT = 128,
  parameter int unsigned SHORT_WORDS  = 8,
  parameter int unsigned WORD_BYTES   = 4,
  localparam int unsigned LEN_W = $clog2(16 * WORD_BYTES + 1),
  localparam int unsigned PW_W  = (ALT_FLD_W > NRM_FLD_W) ? ALT_FLD_W : NRM_FLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [31:0]       stride_word_i,
  input  logic              alt_layout_i,
  input  logic [1:0]        pix_fmt_i,
  input  logic [FBW_W-1:0]  fb_width_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [PW_W-1:0]  page_w, gap;
  logic [LEN_W-1:0] burst_bytes;

  wlag_stride_unpack #(
    .WORD_W   (32),
    .NRM_FLD_W(NRM_FLD_W),
    .ALT_FLD_W(ALT_FLD_W)
  ) i_unpack (
    .stride_word_i(stride_word_i),
    .alt_layout_i (alt_layout_i),
    .page_w_o     (page_w),
    .gap_o        (gap)
  );

  wlag_burst_sel #(
    .FBW_W       (FBW_W),
    .NARROW_LIMIT(NARROW_LIMIT),
    .SHORT_WORDS (SHORT_WORDS),
    .WORD_BYTES  (WORD_BYTES),
    .LEN_W       (LEN_W)
  ) i_burst_sel (
    .fmt_i        (pix_fmt_e'(pix_fmt_i)),
    .fb_width_i   (fb_width_i),
    .burst_bytes_o(burst_bytes)
  );

  wlag_walker #(
    .ADDR_W(ADDR_W),
    .PW_W  (PW_W),
    .LEN_W (LEN_W)
  ) i_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .base_i  (base_addr_i),
    .end_i   (end_addr_i),
    .page_w_i(page_w),
    .gap_i   (gap),
    .burst_i (burst_bytes),
    .ready_i (req_ready_i),
    .valid_o (req_valid_o),
    .addr_o  (req_addr_o),
    .len_o   (req_len_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/win_line_addr_gen_chk.sv
module win_line_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [LEN_W-1:0]  req_len_o,
  input logic              busy_o,
  input logic              done_o
);
  p_hold_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

  p_len_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0 && req_len_o <= LEN_W'(64)));

  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!req_valid_o && !busy_o));

  p_after_fire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> (req_valid_o || done_o));

  p_busy_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == req_valid_o);
endmodule

bind win_line_addr_gen win_line_addr_gen_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_addr_o (req_addr_o),
  .req_len_o  (req_len_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/test_win_line_addr_gen.sv
module test_win_line_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [31:0] end_addr_i = '0;
  logic [31:0] stride_word_i = '0;
  logic        alt_layout_i = 1'b0;
  logic [1:0]  pix_fmt_i = '0;
  logic [12:0] fb_width_i = '0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [31:0] req_addr_o;
  logic [6:0]  req_len_o;
  logic        busy_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  win_line_addr_gen i_win_line_addr_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .base_addr_i(base_addr_i), .end_addr_i(end_addr_i),
    .stride_word_i(stride_word_i), .alt_layout_i(alt_layout_i),
    .pix_fmt_i(pix_fmt_i), .fb_width_i(fb_width_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_burst(input int fbw);
    return (fbw < 128) ? 32 : 64;
  endfunction

  function automatic logic [31:0] pack_stride(input bit alt, input int pw,
                                              input int gap, input logic [3:0] junk);
    logic [31:0] w;
    if (alt) w = {junk[1:0], 15'(gap), 15'(pw)};
    else     w = {junk, 14'(gap), 14'(pw)};
    return w;
  endfunction

  // walk one window; compares every accepted request against a model
  task automatic run_case(input string tag, input longint base, input int pw,
                          input int gap, input int h, input bit alt,
                          input int fmt, input int fbw, input bit poke_busy,
                          input int ready_pct);
    longint endv, m_line, n_line;
    int     m_pos, bl, elen, fires, exp_fires, line_i, cyc;
    bit     m_fin;
    endv = base + longint'(pw + gap) * h;
    bl = exp_burst(fbw);
    exp_fires = (pw == 0 || h == 0) ? 0 : h * ((pw + bl - 1) / bl);
    @(negedge clk_i);
    base_addr_i   = base[31:0];
    end_addr_i    = endv[31:0];
    stride_word_i = pack_stride(alt, pw, gap, 4'($urandom));
    alt_layout_i  = alt;
    pix_fmt_i     = 2'(fmt);
    fb_width_i    = 13'(fbw);
    start_i       = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    base_addr_i = 32'($urandom);
    stride_word_i = 32'($urandom);
    fb_width_i = 13'($urandom);
    m_line = base; m_pos = 0; fires = 0; line_i = 0; m_fin = (exp_fires == 0);
    if (m_fin) begin
      check({tag, " R11 done"}, done_o, 1);
      check({tag, " R11 valid"}, req_valid_o, 0);
    end else begin
      check({tag, " R2 done cleared"}, done_o, 0);
      check({tag, " R2 first addr"}, req_addr_o, base[31:0]);
    end
    cyc = 0;
    while (!done_o && cyc < 40000) begin
      req_ready_i = (($urandom % 100) < ready_pct);
      if (poke_busy && fires == 1) begin
        start_i = 1'b1;
        end_addr_i = 32'($urandom);
      end
      #1;
      if (req_valid_o && req_ready_i) begin
        elen = (pw - m_pos < bl) ? pw - m_pos : bl;
        check({tag, (alt ? " R4" : " R3"), " R7 R8 addr"}, req_addr_o,
              (m_line + m_pos) & 64'hFFFF_FFFF);
        check({tag, (fbw < 128 ? " R6" : " R5"), " R7 len"}, req_len_o, elen);
        fires++;
        if (m_pos + elen == pw) begin
          n_line = m_line + pw + gap;
          m_pos = 0; line_i++;
          if (n_line >= endv) m_fin = 1;
          m_line = n_line;
        end else m_pos += elen;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      cyc++;
    end
    req_ready_i = 1'b0;
    check({tag, " R9 done"}, done_o, 1);
    check({tag, " R9 model finished"}, m_fin, 1);
    check({tag, " R9 request count"}, fires, exp_fires);
    check({tag, " R2 busy poke ignored"}, line_i, (exp_fires == 0) ? 0 : h);
    repeat (3) @(negedge clk_i);
    req_ready_i = 1'b1;
    #1;
    check({tag, " R9 done held"}, done_o, 1);
    check({tag, " R9 no request after done"}, req_valid_o, 0);
    req_ready_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 valid", req_valid_o, 0);
    check("R1 done", done_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 busy after reset", busy_o, 0);
    check("R1 valid after reset", req_valid_o, 0);
    check("R1 done after reset", done_o, 0);

    // directed corners
    run_case("exact bursts", 32'h1000, 128, 0, 3, 0, 3, 200, 0, 100);
    run_case("fbw 127", 32'h2000, 100, 28, 2, 0, 0, 127, 0, 60);
    run_case("fbw 128", 32'h2000, 100, 28, 2, 1, 1, 128, 0, 60);
    run_case("zero width", 32'h3000, 0, 16, 4, 0, 2, 300, 0, 100);
    run_case("empty span", 32'h4000, 64, 0, 0, 1, 2, 300, 0, 100);
    run_case("wide alt", 32'h8000_0000, 16400, 20000, 1, 1, 3, 4100, 0, 90);
    run_case("busy poke", 32'h5000, 90, 10, 3, 0, 1, 64, 1, 50);
    run_case("stall heavy", 32'h6000, 70, 6, 2, 1, 2, 500, 0, 15);

    for (int i = 0; i < 40; i++) begin
      bit alt;
      int pw, gap, h, fbw;
      alt = 1'($urandom);
      pw  = 1 + ($urandom % 300);
      gap = $urandom % 120;
      h   = 1 + ($urandom % 6);
      fbw = 32 + ($urandom % 300);
      run_case("random", longint'($urandom % 32'h0100_0000) * 4, pw, gap, h,
               alt, $urandom % 4, fbw, 1'($urandom % 4 == 0), 30 + ($urandom % 70));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule